// File: doc/BRIEF.md
# Dual-Word Interrupt Cause Aggregator

This block gathers 64 level-sensitive interrupt sources into a 64-bit cause vector, qualifies that vector with a 64-bit CPU mask and drives a single registered CPU interrupt line. Each source passes through a short synchroniser. Each cause bit then tracks its source level, with no latching and no clear-on-read. Source positions 29 to 31, 35, 51 to 55 and 61 to 63 are reserved and always read as zero.

Software sees five 32-bit registers on a simple write-strobe and combinational-read port:

| Offset | Register |
|---|---|
| 0 | cause bits 31:0 |
| 1 | cause bits 63:32 |
| 2 | mask bits 31:0 |
| 3 | mask bits 63:32 |
| 4 | select-cause |

The select-cause register lets an interrupt handler fetch, in one read, the cause half that holds the pending masked interrupts. Flag bits 30 and 31 report which half that is. These flag positions are free because the matching source numbers are reserved.

Top module: `irq_cause_agg`

## Requirements
- R1: A source change appears in the cause registers exactly 2 clock edges after it is sampled. Cause bit n sits at offset 0 bit n for n < 32 and at offset 1 bit n-32 otherwise. The cause bit is 1 while the source is 1 and 0 while the source is 0.
- R2: Cause bits 29, 30, 31, 35, 51 to 55 and 61 to 63 always read 0, whatever their sources do.
- R3: A write to offset 2 loads mask bits 31:0 and leaves mask bits 63:32 unchanged.
- R4: A write to offset 3 loads mask bits 63:32 and leaves mask bits 31:0 unchanged.
- R5: After reset, both the cause and the mask read 0 and irq_o is 0.
- R6: irq_o equals the OR of (cause AND mask) one clock edge after that value is formed. A mask write therefore reaches irq_o one edge after it is written.
- R7: Select-cause (offset 4) returns cause bits 31:0 unchanged when (cause AND mask) is zero.
- R8: When masked pending bits exist only in bits 63:32, select-cause returns cause bits 63:32 with bit 30 set.
- R9: When masked pending bits exist in both halves, select-cause returns cause bits 31:0 with bit 31 set.
- R10: When masked pending bits exist only in bits 31:0, select-cause returns cause bits 31:0 unchanged.
- R11: Writes to offsets 0, 1 and 4 change neither the cause nor the mask. Offsets 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Interrupt source levels, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Registered CPU interrupt |

## Verification
A wrong synchroniser depth shows as a cause read that changes one cycle early or late. A mask half that is clobbered shows at the next read of the other half. It also shows one edge later as irq_o rising or falling against the model.

A select-cause decode error appears on the very read that follows a settled source and mask pattern. Sweeping each source alone under four mask patterns, plus pseudo-random multi-bit patterns, covers all three flag outcomes on both halves.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CAUSE_LO = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CAUSE_HI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SEL      = 3'd4;

  localparam int unsigned FLAG_HI_ONLY = 30;
  localparam int unsigned FLAG_BOTH    = 31;

  localparam logic [2*WORD_W-1:0] RSVD_SRC = 64'hE0F8_0008_E000_0000;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALVES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [HALVES-1:0]        wr_half_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [HALVES*WORD_W-1:0] mask_o
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [WORD_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          half_q <= '0;
      else if (wr_half_i[h]) half_q <= wdata_i;
    end
    assign mask_o[h*WORD_W +: WORD_W] = half_q;
  end
endmodule

// File: rtl/irq_sel_encode.sv
module irq_sel_encode #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FLAG_HI = 30,
  parameter int unsigned FLAG_BT = 31
) (
  input  logic [2*WORD_W-1:0] cause_i,
  input  logic [2*WORD_W-1:0] mask_i,
  output logic [WORD_W-1:0]   sel_o
);
  logic [2*WORD_W-1:0] pend;
  logic                any_lo, any_hi;

  assign pend   = cause_i & mask_i;
  assign any_lo = |pend[WORD_W-1:0];
  assign any_hi = |pend[2*WORD_W-1:WORD_W];

  always_comb begin
    sel_o = cause_i[WORD_W-1:0];
    if (any_hi && !any_lo) begin
      sel_o          = cause_i[2*WORD_W-1:WORD_W];
      sel_o[FLAG_HI] = 1'b1;
    end else if (any_hi && any_lo) begin
      sel_o[FLAG_BT] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*WORD_W-1:0] src_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned NSRC = 2 * WORD_W;

  logic [NSRC-1:0]   sync_w, cause_w, mask_w;
  logic [1:0]        wr_half;
  logic [WORD_W-1:0] sel_w;
  logic              irq_q;

  irq_src_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(src_i), .q_o(sync_w)
  );

  // reserved sources tied low
  assign cause_w = sync_w & ~RSVD_SRC;

  assign wr_half = {we_i && (addr_i == OFS_MASK_HI), we_i && (addr_i == OFS_MASK_LO)};

  irq_mask_regs #(.WORD_W(WORD_W), .HALVES(2)) u_mask (
    .clk_i, .rst_ni, .wr_half_i(wr_half), .wdata_i, .mask_o(mask_w)
  );

  irq_sel_encode #(.WORD_W(WORD_W), .FLAG_HI(FLAG_HI_ONLY), .FLAG_BT(FLAG_BOTH)) u_sel (
    .cause_i(cause_w), .mask_i(mask_w), .sel_o(sel_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause_w & mask_w);
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (addr_i)
      OFS_CAUSE_LO: rdata_o = cause_w[WORD_W-1:0];
      OFS_CAUSE_HI: rdata_o = cause_w[NSRC-1:WORD_W];
      OFS_MASK_LO:  rdata_o = mask_w[WORD_W-1:0];
      OFS_MASK_HI:  rdata_o = mask_w[NSRC-1:WORD_W];
      OFS_SEL:      rdata_o = sel_w;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk
  import irq_agg_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [WORD_W-1:0]   rdata_o,
  input logic                irq_o,
  input logic [2*WORD_W-1:0] cause_w,
  input logic [2*WORD_W-1:0] mask_w
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_w & RSVD_SRC) == '0);

  assert_lo_keeps_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MASK_LO) |=> $stable(mask_w[2*WORD_W-1:WORD_W]));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MASK_HI) |=> $stable(mask_w[WORD_W-1:0]));

  assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(cause_w & mask_w)));

  assert_sel_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_SEL && (cause_w & mask_w) == '0) |-> rdata_o == cause_w[WORD_W-1:0]);

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_SEL) |-> !(rdata_o[FLAG_HI_ONLY] && rdata_o[FLAG_BOTH]));
endmodule

bind irq_cause_agg irq_cause_agg_chk u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .rdata_o, .irq_o,
  .cause_w(cause_w), .mask_w(mask_w)
);

// File: tb/irq_cause_agg_test.sv
module irq_cause_agg_test;
  localparam int CLK_P = 10;
  localparam logic [63:0] RSVD = 64'hE0F8_0008_E000_0000;

  logic        clk = 0, rst_ni = 0, we = 0;
  logic [63:0] src = '0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] m_mask = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_cause_agg uut (
    .clk_i(clk), .rst_ni, .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    if (a == 3'd2) m_mask[31:0] = d;
    if (a == 3'd3) m_mask[63:32] = d;
  endtask

  function automatic logic [31:0] exp_sel(input logic [63:0] c, input logic [63:0] m);
    logic [63:0] p = c & m;
    if (p[63:32] != 0 && p[31:0] == 0) return c[63:32] | 32'h4000_0000;
    if (p[63:32] != 0) return c[31:0] | 32'h8000_0000;
    return c[31:0];
  endfunction

  task automatic check_all(input string tag);
    logic [63:0] c = src & ~RSVD;
    logic [31:0] d;
    logic [63:0] p = c & m_mask;
    rd(3'd0, d); chk({tag, " R1 lo"}, d, c[31:0]);
    rd(3'd1, d); chk({tag, " R1 hi"}, d, c[63:32]);
    rd(3'd4, d);
    if (p == 0)               chk({tag, " R7"}, d, exp_sel(c, m_mask));
    else if (p[31:0] == 0)    chk({tag, " R8"}, d, exp_sel(c, m_mask));
    else if (p[63:32] != 0)   chk({tag, " R9"}, d, exp_sel(c, m_mask));
    else                      chk({tag, " R10"}, d, exp_sel(c, m_mask));
    chk({tag, " R6 irq"}, {31'd0, irq}, {31'd0, |p});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk);
    // R5 reset state
    for (int a = 0; a < 5; a++) begin rd(a[2:0], d); chk("R5 reset reg", d, 32'h0); end
    chk("R5 irq", {31'd0, irq}, 32'h0);
    rst_ni = 1;
    @(negedge clk);

    // R1 latency
    src = 64'h0000_0001_0000_0001;
    @(negedge clk); rd(3'd0, d); chk("R1 one edge", d, 32'h0);
    @(negedge clk); rd(3'd0, d); chk("R1 two edges", d, 32'h1);
    // R6 timing: mask written, irq follows one edge later
    @(negedge clk); we = 1; addr = 3'd2; wdata = 32'h1;
    @(posedge clk); #1; we = 0; m_mask[31:0] = 32'h1;
    chk("R6 before edge", {31'd0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R6 after edge", {31'd0, irq}, 32'h1);
    wr(3'd2, 32'h0);

    // R2 reserved sources
    src = '1; settle();
    rd(3'd0, d); chk("R2 lo", d, ~RSVD[31:0]);
    rd(3'd1, d); chk("R2 hi", d, ~RSVD[63:32]);

    // R3 / R4 half independence
    wr(3'd2, 32'hA5A5_0F0F); wr(3'd3, 32'h3C3C_9999);
    wr(3'd2, 32'h1111_2222);
    rd(3'd3, d); chk("R3 hi kept", d, 32'h3C3C_9999);
    rd(3'd2, d); chk("R3 lo loaded", d, 32'h1111_2222);
    wr(3'd3, 32'h7777_8888);
    rd(3'd2, d); chk("R4 lo kept", d, 32'h1111_2222);
    rd(3'd3, d); chk("R4 hi loaded", d, 32'h7777_8888);

    // R11 writes to read-only offsets
    src = 64'h0000_0100_0000_0010; settle();
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 cause lo", d, 32'h0000_0010);
    rd(3'd1, d); chk("R11 cause hi", d, 32'h0000_0100);
    rd(3'd2, d); chk("R11 mask lo", d, 32'h1111_2222);
    rd(3'd3, d); chk("R11 mask hi", d, 32'h7777_8888);
    for (int a = 5; a < 8; a++) begin rd(a[2:0], d); chk("R11 unused offset", d, 32'h0); end

    // single-source sweep under four mask patterns
    for (int mp = 0; mp < 4; mp++) begin
      wr(3'd2, mp[0] ? 32'hFFFF_FFFF : 32'h0);
      wr(3'd3, mp[1] ? 32'hFFFF_FFFF : 32'h0);
      for (int i = 0; i < 64; i++) begin
        src = 64'd1 << i; settle(); check_all("sweep");
      end
    end

    // both-halves pattern, R9
    src = 64'h0000_0001_0000_0001; settle(); check_all("both");

    // pseudo-random multi-bit patterns
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      if (k % 3 == 0) wr(3'd2, lfsr[31:0] & {32{lfsr[5]}});
      if (k % 3 == 1) wr(3'd3, lfsr[63:32] & {32{lfsr[9]}});
      src = {lfsr[40:0], lfsr[63:41]} & {{32{lfsr[3]}}, {32{lfsr[7]}}};
      settle(); check_all("rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule